// File: doc/BRIEF.md
# Encoded Bypass Packet Transmitter

This block drains a show-ahead transmit FIFO onto a 16-bit parallel link. Every clock it sends one beat: a 16-bit data word on `txd` and a 3-bit control code on `txc`. The code says where the beat sits in its packet (first, inner, last or only beat) and whether one or two bytes of the word are valid. When there is nothing to send, the block sends a data-not-valid code instead.

The far end can pause the link with the `tx_fc` input. The pause and the resume both take effect a fixed two rising edges after the input changes. No beat is dropped or repeated across a pause. If the FIFO runs dry partway through a packet, the block fills the gap with data-not-valid beats and carries on with the same packet when data returns. A packet is never cut short.

The FIFO presents its head entry whenever `fifo_empty` is low. That entry holds the data word, start and end flags, and a two-bytes-valid flag. The block consumes the entry on any rising edge where `fifo_rd` is high.

Top module: `enc_bypass_tx`

## Requirements
- R1: With nothing sent on an edge, including during and straight after reset, `txc` is 3'b000 (data not valid) and `txd` is 16'h0000.
- R2: A beat with the start flag set and the end flag clear is sent as code 3'b101, and the two-bytes-valid flag is expected to be set. The word goes out unchanged.
- R3: A beat with neither flag set is sent as code 3'b111, with two bytes valid and the word unchanged.
- R4: A beat with the end flag set and the start flag clear is sent as 3'b110 when two bytes are valid. When only one byte is valid it is sent as 3'b100, with the valid byte on `txd[7:0]` and `txd[15:8]` forced to zero.
- R5: A beat with both flags set is a whole packet in one beat. It is sent as 3'b011 for two bytes and as 3'b010 for one byte (one byte on `txd[7:0]`, upper byte zero).
- R6: If `tx_fc` is high at rising edge n, then `fifo_rd` is low during the following cycle and the beat sent at edge n+1 is data-not-valid.
- R7: If `tx_fc` is low at edge n and an entry is waiting, that entry is sent at edge n+1. Across any pattern of pauses, the beats leave in FIFO order, each exactly once.
- R8: When the FIFO is empty inside a packet, data-not-valid beats are inserted. The packet then continues with its next beat, without a fresh start code and without being aborted.
- R9: `fifo_rd` is high only while `fifo_empty` is low, reset is released, and no pause is in effect. Each entry read appears on the link one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_data | input | 16 | Head FIFO word; byte on [7:0] when only one byte is valid |
| fifo_sop | input | 1 | Head entry is the first beat of a packet |
| fifo_eop | input | 1 | Head entry is the last beat of a packet |
| fifo_two | input | 1 | 1: both bytes valid, 0: only the low byte valid |
| fifo_empty | input | 1 | No head entry available |
| fifo_rd | output | 1 | Consume the head entry on this edge |
| tx_fc | input | 1 | Pause request from the link partner |
| txd | output | 16 | Link data |
| txc | output | 3 | Link control code |

## Verification
The assertions assume a well-formed FIFO stream:
- A start flag appears only between packets.
- Every beat after the first belongs to the open packet.
- A one-byte beat always carries the end flag.

The bench keeps to these rules by building whole packets of 1 to 21 bytes before the run. It splits each packet into two-byte beats and gives only the final beat an odd count. Random draws from a fixed seed decide only when the FIFO looks empty and when `tx_fc` toggles, so no random choice can produce an ill-formed packet. The random upper byte on one-byte beats still tests the masking.

// File: rtl/enc_bypass_pkg.sv
package enc_bypass_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    CODE_IDLE  = 3'b000,
    CODE_ONLY1 = 3'b010,
    CODE_ONLY2 = 3'b011,
    CODE_LAST1 = 3'b100,
    CODE_FIRST = 3'b101,
    CODE_LAST2 = 3'b110,
    CODE_INNER = 3'b111
  } beat_code_e;

  // Control code from the position flags and the byte count.
  function automatic beat_code_e code_of(input logic sop, input logic eop, input logic two);
    beat_code_e c;
    if (sop && eop)  c = two ? CODE_ONLY2 : CODE_ONLY1;
    else if (sop)    c = CODE_FIRST;
    else if (eop)    c = two ? CODE_LAST2 : CODE_LAST1;
    else             c = CODE_INNER;
    return c;
  endfunction
endpackage

// File: rtl/enc_bypass_fc_delay.sv
module enc_bypass_fc_delay #(
  parameter int FC_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_fc,
  output logic stall
);
  localparam int STAGES = (FC_LAT > 1) ? FC_LAT - 1 : 1;

  generate
    if (FC_LAT <= 1) begin : g_direct
      assign stall = tx_fc;
    end else begin : g_pipe
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q <= '0;
        end else begin
          sh_q[0] <= tx_fc;
          for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
        end
      end
      assign stall = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/enc_bypass_pkt_tracker.sv
module enc_bypass_pkt_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_rd,
  input  logic fifo_sop,
  input  logic fifo_eop,
  output logic in_pkt,
  output logic bubble
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             in_pkt <= 1'b0;
    else if (fifo_rd) begin
      if (fifo_eop)         in_pkt <= 1'b0;
      else if (fifo_sop)    in_pkt <= 1'b1;
    end
  end

  // A packet is open but no beat leaves on this edge.
  assign bubble = in_pkt && !fifo_rd;

  // R8: beats without a start flag only continue an open packet
  // R8
  cont_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && !fifo_sop) |-> in_pkt);

  // R2: a start flag only arrives between packets
  // R2
  start_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && fifo_sop) |-> !in_pkt);
endmodule

// File: rtl/enc_bypass_beat_reg.sv
module enc_bypass_beat_reg
  import enc_bypass_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              sop,
  input  logic              eop,
  input  logic              two,
  output logic [DATA_W-1:0] txd,
  output logic [CODE_W-1:0] txc
);
  localparam int HALF = DATA_W / 2;

  // One-byte beats keep only the low byte.
  function automatic logic [DATA_W-1:0] lane_of(input logic [DATA_W-1:0] d, input logic t);
    return t ? d : {{(DATA_W-HALF){1'b0}}, d[HALF-1:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd <= '0;
      txc <= CODE_IDLE;
    end else if (load) begin
      txd <= lane_of(data, two);
      txc <= code_of(sop, eop, two);
    end else begin
      txd <= '0;
      txc <= CODE_IDLE;
    end
  end

  // R4
  one_byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txc == CODE_LAST1 || txc == CODE_ONLY1) |-> (txd[DATA_W-1:HALF] == '0));

  // R1
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txc == CODE_IDLE) |-> (txd == '0));
endmodule

// File: rtl/enc_bypass_tx.sv
module enc_bypass_tx
  import enc_bypass_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FC_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_sop,
  input  logic              fifo_eop,
  input  logic              fifo_two,
  input  logic              fifo_empty,
  output logic              fifo_rd,
  input  logic              tx_fc,
  output logic [DATA_W-1:0] txd,
  output logic [CODE_W-1:0] txc
);
  logic stall;
  logic in_pkt;
  logic bubble;

  enc_bypass_fc_delay #(.FC_LAT(FC_LAT)) fc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tx_fc (tx_fc),
    .stall (stall)
  );

  assign fifo_rd = rst_n && !stall && !fifo_empty;

  enc_bypass_pkt_tracker trk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_rd  (fifo_rd),
    .fifo_sop (fifo_sop),
    .fifo_eop (fifo_eop),
    .in_pkt   (in_pkt),
    .bubble   (bubble)
  );

  enc_bypass_beat_reg #(.DATA_W(DATA_W)) beat_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fifo_rd),
    .data  (fifo_data),
    .sop   (fifo_sop),
    .eop   (fifo_eop),
    .two   (fifo_two),
    .txd   (txd),
    .txc   (txc)
  );

  // R9
  rd_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  // R6
  pause_blocks_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !fifo_rd);

  // R6
  pause_sends_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (txc == CODE_IDLE));

  // R7
  read_is_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> (txc != CODE_IDLE));

  // R8
  bubble_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (txc == CODE_IDLE));
endmodule

// File: tb/enc_bypass_tx_tb.sv
`timescale 1ns/1ps
module enc_bypass_tx_tb_top;
  localparam int MAXB = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] fifo_data = '0;
  logic        fifo_sop = 1'b0, fifo_eop = 1'b0, fifo_two = 1'b0;
  logic        fifo_empty = 1'b1;
  logic        fifo_rd;
  logic        tx_fc = 1'b0;
  logic [15:0] txd;
  logic [2:0]  txc;

  always #2 clk = ~clk;

  enc_bypass_tx dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data), .fifo_sop(fifo_sop),
    .fifo_eop(fifo_eop), .fifo_two(fifo_two), .fifo_empty(fifo_empty),
    .fifo_rd(fifo_rd), .tx_fc(tx_fc), .txd(txd), .txc(txc)
  );

  logic [15:0] b_data [MAXB];
  logic        b_sop  [MAXB];
  logic        b_eop  [MAXB];
  logic        b_two  [MAXB];
  int nbeats = 0;
  int n_cmp = 0;
  int n_bad = 0;
  int sent = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_code(input logic s, input logic e, input logic t);
    case ({s, e, t})
      3'b111: return 3'b011;
      3'b110: return 3'b010;
      3'b101, 3'b100: return 3'b101;
      3'b011: return 3'b110;
      3'b010: return 3'b100;
      default: return 3'b111;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'b101: return "R2";
      3'b111: return "R3";
      3'b110, 3'b100: return "R4";
      3'b011, 3'b010: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic add_packet(input int len);
    int nb = (len + 1) / 2;
    for (int k = 0; k < nb; k++) begin
      b_data[nbeats] = 16'($urandom);
      b_sop[nbeats]  = (k == 0);
      b_eop[nbeats]  = (k == nb - 1);
      b_two[nbeats]  = !((k == nb - 1) && (len % 2 == 1));
      nbeats++;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R7 watchdog: actual %0d expected %0d", sent, nbeats);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int head = 0;
    bit m_fc1 = 0;
    bit m_inpkt = 0;
    bit pop = 0;
    bit gate;
    logic [2:0]  e_c = 3'b000;
    logic [15:0] e_d = 16'h0;
    string etag = "R1";
    int tail = 0;
    int cyc = 0;
    void'($urandom(32'h5eed_1234));
    // directed packets: 2, 1, 3, 8 bytes, then random 1..21
    add_packet(2); add_packet(1); add_packet(3); add_packet(8);
    while (nbeats < 2500) add_packet(1 + int'($urandom % 21));

    repeat (3) @(negedge clk);
    // R1 reset state
    check(txc == 3'b000 && txd == 16'h0, "R1", "reset idle", {txc, txd}, 0);
    rst_n = 1'b1;

    while (tail < 6 && cyc < 60000) begin
      @(negedge clk);
      check(txc == e_c, (e_c == 3'b000) ? etag : tag_of(e_c), "txc", txc, e_c);
      check(txd == e_d, (e_c == 3'b000) ? etag : tag_of(e_c), "txd", txd, e_d);
      if (txc != 3'b000) sent++;
      // stimulus phases
      if (cyc < 40)       begin gate = 1; tx_fc = 0; end
      else if (cyc < 90)  begin gate = (cyc % 3 != 0); tx_fc = 0; end
      else if (cyc < 140) begin gate = 1; tx_fc = (cyc % 7 < 2); end
      else begin
        gate = ($urandom % 5 != 0);
        if ($urandom % 8 == 0) tx_fc = ~tx_fc;
      end
      fifo_empty = !(gate && head < nbeats);
      if (head < nbeats) begin
        fifo_data = b_data[head]; fifo_sop = b_sop[head];
        fifo_eop = b_eop[head];   fifo_two = b_two[head];
      end
      #1;
      pop = !m_fc1 && gate && head < nbeats;
      check(fifo_rd == pop, m_fc1 ? "R6" : "R9", "fifo_rd", fifo_rd, pop);
      if (pop) begin
        e_c = exp_code(b_sop[head], b_eop[head], b_two[head]);
        e_d = b_two[head] ? b_data[head] : {8'h00, b_data[head][7:0]};
      end else begin
        e_c = 3'b000; e_d = 16'h0;
        etag = m_fc1 ? "R6" : (m_inpkt ? "R8" : "R1");
      end
      @(posedge clk);
      m_fc1 = tx_fc;
      if (pop) begin
        if (b_eop[head]) m_inpkt = 0; else if (b_sop[head]) m_inpkt = 1;
        head++;
      end
      if (head >= nbeats) tail++;
      cyc++;
    end
    @(negedge clk);
    // R7: every beat left exactly once
    check(sent == nbeats, "R7", "beats sent", sent, nbeats);
    check(head == nbeats, "R7", "beats read", head, nbeats);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule